// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind one byte-wide host port. Each channel has a count-enable input that marks the cycles on which it may advance, a GATE input that enables, suspends or triggers it, and a single output whose waveform depends on the channel's mode. The host first writes a configuration byte to the control address. That byte picks a channel, an access format, one of six modes and binary or four-digit BCD arithmetic. The host then writes the initial count to the channel's own address, one or two bytes at a time.

The host interface is synchronous. A write or read happens on a clock edge at which the select input is low and the matching strobe is high. Read data is combinational while the read strobe is applied. A read of a counter returns either the live count or a snapshot taken by a latch command. The six modes are: terminal-count flag, gate-triggered one-shot, periodic rate pulse, square wave, count-started strobe and gate-started strobe. They cover event timing, pulse width generation and periodic ticks.

Top module: `pit_timer3`

## Requirements
- R1: After synchronous reset every channel is in mode 0 with LSB-then-MSB format, binary counting and count zero. All outputs are low and stay low until a channel is programmed.
- R2: A write to address 3 is a control byte. Bits 7:6 choose channel 0, 1 or 2, and the value 3 makes the whole byte ignored. Bits 5:4 are the access format, bits 3:1 the mode and bit 0 selects BCD. A control byte with a nonzero format sets the output low for mode 0 and high for every other mode.
- R3: Count writes to address 0, 1 or 2 follow the format. Format 01 loads the byte as the low half with the high half zero. Format 10 loads the byte as the high half with the low half zero. Format 11 takes the low byte first and then the high byte, and the new count takes effect only on the high-byte write.
- R4: A control byte with format 00 latches the selected channel's count. Reads then return the snapshot until the snapshot has been read out completely: one read for format 01 or 10, both bytes for format 11. Format 11 reads alternate low byte then high byte. Read data is zero unless a counter address is being read.
- R5: With BCD selected, the count decrements as four decimal digits (0100 becomes 0099). Without it, the count decrements as a 16-bit binary value (0100 becomes 00FF).
- R6: Mode 0: after a count N is loaded the output is low. It rises on the Nth enabled cycle and then holds. GATE low freezes the count.
- R7: Mode 1: a GATE rising edge loads N and drives the output low for exactly N enabled cycles. GATE low suspends the count, and a new rising edge restarts the full N.
- R8: Mode 2 (N of 2 or more): the output is high and pulses low for one enabled cycle every N enabled cycles. The count reloads automatically.
- R9: Mode 3 (N of 2 or more): the output is a square wave of period N that is high for (N+1)/2 enabled cycles and low for the rest. GATE has no effect.
- R10: Mode 4: the count starts when it is loaded. The output drops low for one enabled cycle on the Nth enabled cycle. GATE low suspends the count.
- R11: Mode 5: a GATE rising edge loads N and starts the count. The output drops low for one enabled cycle N enabled cycles after the trigger.
- R12: A channel's count and output change only on cycles where its count-enable input is high, except for the effect of a host write.
- R13: Mode codes 110 and 111 select modes 2 and 3, the same as 010 and 011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Host select, active low |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Host address: 0 to 2 counters, 3 control |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte |
| tick | input | 3 | Per-channel count enable |
| gate | input | 3 | Per-channel gate |
| out | output | 3 | Per-channel output |

## Verification
Every mode is swept over initial counts 2 through 9 and run for more than two periods. The expected output for each enabled cycle comes from simple modular arithmetic. This separates the off-by-one points: the cycle a flag rises, the width of a strobe, and the odd high/low split of the square wave. Directed runs then drop GATE or the count enable in the middle of a countdown, and toggle GATE throughout the square wave. This tells suspension apart from reload and from no effect. Byte-level reads with and without a latch, in all three formats, show when a half-written count takes effect. The BCD-versus-binary decrement from 0100 shows which arithmetic is in use.

// File: rtl/pit_pkg.sv
package pit_pkg;

   localparam int CNT_W  = 16;
   localparam int DIGITS = CNT_W / 4;

   localparam logic [1:0] FMT_LATCH = 2'b00;
   localparam logic [1:0] FMT_LO    = 2'b01;
   localparam logic [1:0] FMT_HI    = 2'b10;
   localparam logic [1:0] FMT_WORD  = 2'b11;

   typedef enum logic [2:0] {
      MD_TC      = 3'd0,
      MD_ONESHOT = 3'd1,
      MD_RATE    = 3'd2,
      MD_SQUARE  = 3'd3,
      MD_SWSTB   = 3'd4,
      MD_HWSTB   = 3'd5
   } mode_e;

   // codes x10 and x11 fold onto the rate and square modes
   function automatic mode_e mode_of(input logic [2:0] code);
      if (code[1]) return mode_e'({1'b0, code[1:0]});
      return mode_e'(code);
   endfunction

   // one-step decrement, binary or packed decimal digits
   function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v,
                                                input logic bcd);
      logic [CNT_W-1:0] r;
      logic             brw;
      r   = v;
      brw = 1'b1;
      if (!bcd) begin
         r = v - 1'b1;
      end else begin
         for (int d = 0; d < DIGITS; d++) begin
            if (brw) begin
               if (v[4*d +: 4] == 4'd0) begin
                  r[4*d +: 4] = 4'd9;
               end else begin
                  r[4*d +: 4] = v[4*d +: 4] - 4'd1;
                  brw = 1'b0;
               end
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode #(
   parameter int N_CH = 3
) (
   input  logic            sel_n,
   input  logic            wr_en,
   input  logic            rd_en,
   input  logic [1:0]      addr,
   input  logic [3:0]      ctl_hi,
   output logic [N_CH-1:0] ctl_we,
   output logic [N_CH-1:0] lat_cmd,
   output logic [N_CH-1:0] dat_we,
   output logic [N_CH-1:0] dat_re
);
   import pit_pkg::*;

   localparam logic [1:0] CTL_ADDR = 2'd3;

   logic       wr_hit;
   logic       rd_hit;
   logic       ctl_hit;
   logic [1:0] sc;
   logic [1:0] rl;

   assign wr_hit  = wr_en && !sel_n;
   assign rd_hit  = rd_en && !sel_n;
   assign ctl_hit = wr_hit && (addr == CTL_ADDR);
   assign sc      = ctl_hi[3:2];
   assign rl      = ctl_hi[1:0];

   for (genvar g = 0; g < N_CH; g++) begin : g_dec
      assign ctl_we[g]  = ctl_hit && (sc == 2'(g)) && (rl != FMT_LATCH);
      assign lat_cmd[g] = ctl_hit && (sc == 2'(g)) && (rl == FMT_LATCH);
      assign dat_we[g]  = wr_hit && (addr == 2'(g));
      assign dat_re[g]  = rd_hit && (addr == 2'(g));
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       gate,
   input  logic       ctl_we,
   input  logic [5:0] ctl_bits,
   input  logic       lat_cmd,
   input  logic       dat_we,
   input  logic       dat_re,
   input  logic [7:0] wdata,
   output logic       out,
   output logic [7:0] rbyte
);
   import pit_pkg::*;

   localparam int HB = CNT_W / 2;

   logic [1:0]       fmt;
   mode_e            mode;
   mode_e            new_mode;
   logic             bcd;
   logic [CNT_W-1:0] cnt, rld, lat, dn, dn2, ld_val, src;
   logic [HB-1:0]    lo_hold;
   logic             wflip, rflip, latched;
   logic             run, armed, pend, gate_q, xtra;
   logic             rise, trig, ld_go;

   assign new_mode = mode_of(ctl_bits[3:1]);
   assign rise     = gate && !gate_q;
   assign trig     = rise || pend;
   assign dn       = cnt_dec(cnt, bcd);
   assign dn2      = cnt_dec(dn, bcd);

   always_comb begin
      ld_go  = 1'b0;
      ld_val = '0;
      case (fmt)
         FMT_LO:   begin ld_go = dat_we;          ld_val = {{HB{1'b0}}, wdata}; end
         FMT_HI:   begin ld_go = dat_we;          ld_val = {wdata, {HB{1'b0}}}; end
         FMT_WORD: begin ld_go = dat_we && wflip; ld_val = {wdata, lo_hold};    end
         default:  begin ld_go = 1'b0;            ld_val = '0;                  end
      endcase
   end

   assign src = latched ? lat : cnt;

   always_comb begin
      case (fmt)
         FMT_HI:   rbyte = src[CNT_W-1:HB];
         FMT_WORD: rbyte = rflip ? src[CNT_W-1:HB] : src[HB-1:0];
         default:  rbyte = src[HB-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fmt     <= FMT_WORD;
         mode    <= MD_TC;
         bcd     <= 1'b0;
         cnt     <= '0;
         rld     <= '0;
         lat     <= '0;
         lo_hold <= '0;
         wflip   <= 1'b0;
         rflip   <= 1'b0;
         latched <= 1'b0;
         run     <= 1'b0;
         armed   <= 1'b0;
         pend    <= 1'b0;
         gate_q  <= 1'b0;
         xtra    <= 1'b0;
         out     <= 1'b0;
      end else begin
         gate_q <= gate;
         pend   <= tick ? 1'b0 : (pend || rise);
         if (ctl_we) begin
            fmt     <= ctl_bits[5:4];
            mode    <= new_mode;
            bcd     <= ctl_bits[0];
            out     <= (new_mode != MD_TC);
            run     <= 1'b0;
            armed   <= 1'b0;
            wflip   <= 1'b0;
            rflip   <= 1'b0;
            latched <= 1'b0;
            xtra    <= 1'b0;
            pend    <= 1'b0;
         end else begin
            if (dat_we && fmt == FMT_WORD) begin
               wflip <= !wflip;
               if (!wflip) lo_hold <= wdata;
            end
            if (lat_cmd && !latched) begin
               latched <= 1'b1;
               lat     <= cnt;
            end
            if (dat_re) begin
               if (fmt == FMT_WORD) rflip <= !rflip;
               if (latched && (fmt != FMT_WORD || rflip)) latched <= 1'b0;
            end
            if (ld_go) begin
               rld  <= ld_val;
               xtra <= 1'b0;
               case (mode)
                  MD_TC:      begin cnt <= ld_val; run <= 1'b1; out <= 1'b0; end
                  MD_RATE:    begin cnt <= ld_val; run <= 1'b1; out <= 1'b1; end
                  MD_SQUARE:  begin cnt <= {ld_val[CNT_W-1:1], 1'b0}; run <= 1'b1; out <= 1'b1; end
                  MD_SWSTB:   begin cnt <= ld_val; run <= 1'b1; out <= 1'b1; end
                  default:    begin armed <= 1'b1; end
               endcase
            end else if (tick) begin
               case (mode)
                  MD_TC: begin
                     if (run && gate && cnt != '0) begin
                        cnt <= dn;
                        if (cnt == CNT_W'(1)) out <= 1'b1;
                     end
                  end
                  MD_ONESHOT: begin
                     if (armed && trig) begin
                        cnt <= rld; out <= 1'b0; run <= 1'b1;
                     end else if (run && gate) begin
                        cnt <= dn;
                        if (cnt == CNT_W'(1)) begin out <= 1'b1; run <= 1'b0; end
                     end
                  end
                  MD_RATE: begin
                     if (run && gate) begin
                        if (cnt <= CNT_W'(1)) begin
                           cnt <= rld; out <= 1'b1;
                        end else begin
                           cnt <= dn; out <= (cnt != CNT_W'(2));
                        end
                     end
                  end
                  MD_SQUARE: begin
                     if (run) begin
                        if (cnt <= CNT_W'(2)) begin
                           if (out && rld[0] && !xtra) begin
                              xtra <= 1'b1;
                           end else begin
                              out  <= !out;
                              cnt  <= {rld[CNT_W-1:1], 1'b0};
                              xtra <= 1'b0;
                           end
                        end else begin
                           cnt <= dn2;
                        end
                     end
                  end
                  MD_SWSTB: begin
                     if (!out) begin
                        out <= 1'b1;
                     end else if (run && gate) begin
                        cnt <= dn;
                        if (cnt == CNT_W'(1)) begin out <= 1'b0; run <= 1'b0; end
                     end
                  end
                  default: begin
                     if (armed && trig) begin
                        cnt <= rld; run <= 1'b1; out <= 1'b1;
                     end else if (!out) begin
                        out <= 1'b1;
                     end else if (run) begin
                        cnt <= dn;
                        if (cnt == CNT_W'(1)) begin out <= 1'b0; run <= 1'b0; end
                     end
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/pit_timer3.sv
module pit_timer3 #(
   parameter int N_CH = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sel_n,
   input  logic            wr_en,
   input  logic            rd_en,
   input  logic [1:0]      addr,
   input  logic [7:0]      wdata,
   output logic [7:0]      rdata,
   input  logic [N_CH-1:0] tick,
   input  logic [N_CH-1:0] gate,
   output logic [N_CH-1:0] out
);
   import pit_pkg::*;

   if (N_CH < 1 || N_CH > 3) begin : g_bad_nch
      $error("pit_timer3: N_CH must be 1..3, the control address takes the fourth slot");
   end
   if (CNT_W != 16) begin : g_bad_width
      $error("pit_timer3: counters must be 16 bits for two-byte access");
   end

   logic [N_CH-1:0]      ctl_we, lat_cmd, dat_we, dat_re;
   logic [N_CH-1:0][7:0] rbyte;

   pit_bus_decode #(.N_CH(N_CH)) u_dec (
      .sel_n   (sel_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .ctl_hi  (wdata[7:4]),
      .ctl_we  (ctl_we),
      .lat_cmd (lat_cmd),
      .dat_we  (dat_we),
      .dat_re  (dat_re)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pit_channel u_ch (
         .clk      (clk),
         .rst      (rst),
         .tick     (tick[c]),
         .gate     (gate[c]),
         .ctl_we   (ctl_we[c]),
         .ctl_bits (wdata[5:0]),
         .lat_cmd  (lat_cmd[c]),
         .dat_we   (dat_we[c]),
         .dat_re   (dat_re[c]),
         .wdata    (wdata),
         .out      (out[c]),
         .rbyte    (rbyte[c])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (dat_re[i]) rdata = rbyte[i];
      end
   end

endmodule

// File: rtl/pit_timer3_chk.sv
module pit_timer3_chk #(
   parameter int N_CH = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            sel_n,
   input logic            wr_en,
   input logic            rd_en,
   input logic [1:0]      addr,
   input logic [7:0]      wdata,
   input logic [7:0]      rdata,
   input logic [N_CH-1:0] tick,
   input logic [N_CH-1:0] out
);

   logic bus_wr;
   assign bus_wr = wr_en && !sel_n;

   // R1: outputs come out of reset low
   a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (out == '0));

   // R2: a control byte naming channel 3 touches no output
   a_r2_illegal_sc_ignored: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && addr == 2'd3 && wdata[7:6] == 2'b11 && tick == '0) |=> $stable(out));

   // R4: read bus idles at zero unless a counter is read
   a_r4_rdata_idle: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && !sel_n && int'(addr) < N_CH) |-> (rdata == 8'h00));

   // R12: no enable and no write means a frozen output
   for (genvar i = 0; i < N_CH; i++) begin : g_idle
      a_r12_out_frozen: assert property (@(posedge clk) disable iff (rst)
         (!tick[i] && !bus_wr) |=> $stable(out[i]));
   end

endmodule

bind pit_timer3 pit_timer3_chk #(.N_CH(N_CH)) i_chk (
   .clk   (clk),
   .rst   (rst),
   .sel_n (sel_n),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .addr  (addr),
   .wdata (wdata),
   .rdata (rdata),
   .tick  (tick),
   .out   (out)
);

// File: tb/test_pit_timer3.sv
module test_pit_timer3;

   logic       clk = 1'b0;
   logic       rst;
   logic       sel_n, wr_en, rd_en;
   logic [1:0] addr;
   logic [7:0] wdata, rdata, rb;
   logic [2:0] tick, gate, out;

   int n_vec = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   pit_timer3 #(.N_CH(3)) i_pit_timer3 (
      .clk(clk), .rst(rst), .sel_n(sel_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .out(out)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      sel_n = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel_n = 1'b1; wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      sel_n = 1'b0; rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel_n = 1'b1; rd_en = 1'b0;
   endtask

   // sweep one mode on one channel, expected output computed per enabled cycle
   task automatic run_case(input int m, input logic [2:0] code, input int n);
      int    ch;
      logic  e;
      string tag;
      ch = m % 3;
      case (m)
         0: tag = "R6"; 1: tag = "R7"; 2: tag = "R8";
         3: tag = "R9"; 4: tag = "R10"; default: tag = "R11";
      endcase
      if (code[2] && code[1]) tag = {tag, "/R13"};
      tick = '0; gate = '0;
      step(1);
      wr(2'd3, {2'(ch), 2'b11, code, 1'b0});
      chk("R2", 16'(out[ch]), 16'(m != 0));
      wr(2'(ch), 8'(n));
      wr(2'(ch), 8'h00);
      tick[ch] = 1'b1;
      gate[ch] = (m != 3);
      for (int k = 1; k <= 2 * n + 3; k++) begin
         step(1);
         if (m == 3) gate[ch] = ~gate[ch];
         case (m)
            0: e = (k >= n);
            1: e = (k > n);
            2: e = ((k % n) != n - 1);
            3: e = ((k % n) < (n + 1) / 2);
            4: e = (k != n);
            default: e = (k != n + 1);
         endcase
         chk(tag, 16'(out[ch]), 16'(e));
      end
      tick = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      rst = 1'b1; sel_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
      addr = '0; wdata = '0; tick = '0; gate = '0;
      step(3);
      rst = 1'b0;
      step(1);

      // R1 reset state
      chk("R1 out", 16'(out), 16'h0);
      chk("R1 rdata idle", 16'(rdata), 16'h0);
      rd(2'd0, rb); chk("R1 count zero", 16'(rb), 16'h00);
      step(4);
      chk("R1 out stays low", 16'(out), 16'h0);

      // R3/R4 access formats on channel 1
      wr(2'd3, 8'h50);                      // ch1, low byte only, mode 0
      wr(2'd1, 8'h07);
      rd(2'd1, rb); chk("R3 low-only load", 16'(rb), 16'h07);
      rd(2'd1, rb); chk("R4 low-only reread", 16'(rb), 16'h07);
      wr(2'd3, 8'h60);                      // ch1, high byte only
      wr(2'd1, 8'h02);
      rd(2'd1, rb); chk("R3 high-only load", 16'(rb), 16'h02);
      gate[1] = 1'b1; tick[1] = 1'b1; step(1); tick = '0;
      rd(2'd1, rb); chk("R5 binary high after dec", 16'(rb), 16'h01);
      wr(2'd3, 8'h70);                      // ch1, low then high
      wr(2'd1, 8'h05);
      rd(2'd1, rb); chk("R3 half write no effect lo", 16'(rb), 16'hFF);
      rd(2'd1, rb); chk("R3 half write no effect hi", 16'(rb), 16'h01);
      wr(2'd1, 8'h01);
      rd(2'd1, rb); chk("R3 word lo", 16'(rb), 16'h05);
      rd(2'd1, rb); chk("R4 word hi", 16'(rb), 16'h01);
      rd(2'd3, rb); chk("R4 control read zero", 16'(rb), 16'h00);

      // R4 latch on channel 0
      gate = '0;
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h2C); wr(2'd0, 8'h01);     // 300
      gate[0] = 1'b1; tick[0] = 1'b1; step(5); tick = '0;
      wr(2'd3, 8'h00);                      // latch ch0
      tick[0] = 1'b1; step(3); tick = '0;
      rd(2'd0, rb); chk("R4 latched lo", 16'(rb), 16'h27);
      rd(2'd0, rb); chk("R4 latched hi", 16'(rb), 16'h01);
      rd(2'd0, rb); chk("R4 live lo after release", 16'(rb), 16'h24);
      rd(2'd0, rb); chk("R4 live hi after release", 16'(rb), 16'h01);

      // R5 BCD versus binary on channel 2
      gate = '0;
      wr(2'd3, 8'hB1);
      wr(2'd2, 8'h00); wr(2'd2, 8'h01);
      gate[2] = 1'b1; tick[2] = 1'b1; step(1); tick = '0;
      rd(2'd2, rb); chk("R5 bcd lo", 16'(rb), 16'h99);
      rd(2'd2, rb); chk("R5 bcd hi", 16'(rb), 16'h00);
      tick[2] = 1'b1; step(98);
      chk("R5 bcd not yet zero", 16'(out[2]), 16'h0);
      step(1);
      chk("R5 bcd reaches zero at 100", 16'(out[2]), 16'h1);
      tick = '0;
      wr(2'd3, 8'hB0);
      wr(2'd2, 8'h00); wr(2'd2, 8'h01);
      tick[2] = 1'b1; step(1); tick = '0;
      rd(2'd2, rb); chk("R5 binary lo", 16'(rb), 16'hFF);
      rd(2'd2, rb); chk("R5 binary hi", 16'(rb), 16'h00);

      // R6 gate suspends mode 0
      gate = '0;
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h06); wr(2'd0, 8'h00);
      gate[0] = 1'b1; tick[0] = 1'b1; step(3);
      gate[0] = 1'b0; step(4);
      chk("R6 held by gate", 16'(out[0]), 16'h0);
      gate[0] = 1'b1; step(2);
      chk("R6 one left", 16'(out[0]), 16'h0);
      step(1);
      chk("R6 terminal after resume", 16'(out[0]), 16'h1);
      tick = '0;

      // R12 count enable freezes mode 0
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h06); wr(2'd0, 8'h00);
      tick[0] = 1'b1; step(3);
      tick[0] = 1'b0; step(5);
      chk("R12 frozen without enable", 16'(out[0]), 16'h0);
      tick[0] = 1'b1; step(2);
      chk("R12 one left", 16'(out[0]), 16'h0);
      step(1);
      chk("R12 terminal", 16'(out[0]), 16'h1);
      tick = '0;

      // R10 gate suspends mode 4
      gate = '0;
      wr(2'd3, 8'h78);
      wr(2'd1, 8'h04); wr(2'd1, 8'h00);
      gate[1] = 1'b1; tick[1] = 1'b1; step(2);
      gate[1] = 1'b0; step(3);
      chk("R10 held high", 16'(out[1]), 16'h1);
      gate[1] = 1'b1; step(1);
      chk("R10 one left", 16'(out[1]), 16'h1);
      step(1);
      chk("R10 strobe low", 16'(out[1]), 16'h0);
      step(1);
      chk("R10 strobe one cycle", 16'(out[1]), 16'h1);
      tick = '0;

      // R7 one-shot suspend and retrigger
      gate = '0;
      wr(2'd3, 8'hB2);
      wr(2'd2, 8'h05); wr(2'd2, 8'h00);
      tick[2] = 1'b1; step(2);
      chk("R7 idle before trigger", 16'(out[2]), 16'h1);
      gate[2] = 1'b1; step(1);
      chk("R7 triggered low", 16'(out[2]), 16'h0);
      step(1);
      gate[2] = 1'b0; step(3);
      chk("R7 suspended low", 16'(out[2]), 16'h0);
      gate[2] = 1'b1;
      for (int k = 1; k <= 7; k++) begin
         step(1);
         chk("R7 retrigger width", 16'(out[2]), 16'(k > 5));
      end
      tick = '0;

      // sweeps over all modes and counts
      for (int m = 0; m < 6; m++) begin
         for (int n = 2; n <= 9; n++) run_case(m, 3'(m), n);
      end
      for (int n = 2; n <= 5; n++) begin
         run_case(2, 3'b110, n);
         run_case(3, 3'b111, n);
      end

      // R2 illegal channel select
      gate = '0;
      wr(2'd3, 8'h38);
      wr(2'd0, 8'h09); wr(2'd0, 8'h00);
      wr(2'd3, 8'hF2);
      chk("R2 illegal word out", 16'(out[0]), 16'h1);
      rd(2'd0, rb); chk("R2 illegal word count lo", 16'(rb), 16'h09);
      rd(2'd0, rb); chk("R2 illegal word count hi", 16'(rb), 16'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

endmodule